// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block owns the program counter of a core that runs a stream of 16-bit fixed-length instructions, one per clock. In every cycle it looks at the opcode that sits at the current PC, together with the condition flag T and one register operand supplied by the register file. From these it decides the next PC and whether the instruction writes a return address into the procedure register. It also raises a one-cycle strobe when a control-flow instruction sits where it is not allowed.

There are two kinds of branch. Immediate conditional branches redirect at once and have no delay slot. Delayed branches let exactly one following instruction, the slot instruction, run before the PC moves to the target. The delayed kinds are PC-relative jumps and calls, delayed conditional branches, register-relative branch and call, register-absolute jump and call, and both returns. The sequencer latches the delayed target and the taken decision in the cycle the branch runs. It holds them across the slot and releases them when the redirect happens.

The surrounding core must present on the operand port the register that the instruction names: Rn for the register forms, and the return-address register for the returns. Fetch, the ALU and exception vectoring sit outside this block.

Top module: `dbc_branch_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the PC is 0xA0000000 and the slot flag is low, even if reset arrives in the middle of a pending delayed branch.
- R2: An instruction outside a slot that is not a branch advances the PC by 2. This includes a trap opcode (0xC3xx), because its vectoring is handled outside the block.
- R3: Branch-if-true 0x89dd and branch-if-false 0x8Bdd compute PC + 4 + sext(dd)×2. When taken they load that target on the next cycle. When not taken they go to PC + 2. In neither case do they open a slot.
- R4: Opcodes with top nibble 0xA (jump) or 0xB (call) open a slot. The slot instruction runs at PC + 2, and the cycle after it the PC becomes branch PC + 4 + sext(low 12 bits)×2.
- R5: Calls (top nibble 0xB, 0x0n03, 0x4n0B) raise the link write in the cycle they run, with link value PC + 4. No other instruction raises it.
- R6: Delayed branch-if-true 0x8Ddd and branch-if-false 0x8Fdd use the same target as R3. T is sampled in the branch's own cycle, and a change of T during the slot has no effect. If the branch is taken the PC moves to the target after the slot; if not, it moves to branch PC + 4.
- R7: 0x0n23 (branch) and 0x0n03 (call) open a slot, and their target is operand + PC + 4. The operand and PC are those of the branch's own cycle, wrapping modulo 2^32.
- R8: 0x4n2B (jump), 0x4n0B (call), 0x000B and 0x002B (returns) open a slot, and their target is the operand value given in the branch's own cycle.
- R9: A branch, call, return or trap opcode in a slot pulses the slot-illegal output in that cycle. It writes no link and does not branch, and the pending redirect still completes to the target latched earlier.
- R10: The slot flag is high during exactly one cycle after each delayed branch, and it clears when the redirect happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 16 | Instruction at the current PC |
| t_flag | input | 1 | Condition flag T |
| opnd | input | 32 | Register operand named by the instruction |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Write strobe for the procedure register |
| link_val | output | 32 | Return address to write (PC + 4) |
| slot_illegal | output | 1 | Control-flow instruction found in a slot |
| in_slot | output | 1 | The current instruction is a delay-slot instruction |

## Verification
The link strobe, link value and slot-illegal strobe are combinational from the opcode and the current state. They are due in the same cycle the stimulus is applied. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the rising edge. The new PC and the slot flag are registered once, so they are compared at the next falling edge, which is one cycle after the instruction that caused them. The slot redirect is checked one cycle later again, when the slot instruction has run. The bench model keeps the latched target and the taken bit itself, so every PC comparison names the requirement of the instruction that produced it.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned INSN_W   = 16;
  localparam int unsigned LDISP_W  = 12;
  localparam int unsigned SDISP_W  = 8;
  localparam int unsigned SEQ_STEP = 2;
  localparam int unsigned PIPE_OFS = 4;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    K_SEQ,      // not a control-flow opcode
    K_IMMCOND,  // conditional, no slot
    K_DLYCOND,  // conditional, one slot
    K_PCREL,    // 12-bit PC-relative, one slot
    K_REGREL,   // register + PC, one slot
    K_REGABS,   // register absolute / return, one slot
    K_TRAP      // trap: only matters when found in a slot
  } flow_kind_e;

  // Sign-extend a 12-bit word displacement and turn it into a byte offset.
  function automatic addr_t long_off(input logic [LDISP_W-1:0] d);
    return {{(ADDR_W-LDISP_W-1){d[LDISP_W-1]}}, d, 1'b0};
  endfunction

  // Sign-extend an 8-bit word displacement and turn it into a byte offset.
  function automatic addr_t short_off(input logic [SDISP_W-1:0] d);
    return {{(ADDR_W-SDISP_W-1){d[SDISP_W-1]}}, d, 1'b0};
  endfunction

  // Base of every PC-relative form: the address two instructions ahead.
  function automatic addr_t ahead(input addr_t pc);
    return pc + addr_t'(PIPE_OFS);
  endfunction

  function automatic addr_t next_seq(input addr_t pc);
    return pc + addr_t'(SEQ_STEP);
  endfunction
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
  import dbc_pkg::*;
(
  input  logic [INSN_W-1:0] opcode,
  output flow_kind_e        kind,
  output logic              is_call,
  output logic              sense
);
  logic [3:0] top_nib;
  logic [7:0] hi_byte;
  logic [7:0] lo_byte;

  assign top_nib = opcode[15:12];
  assign hi_byte = opcode[15:8];
  assign lo_byte = opcode[7:0];

  always_comb begin
    kind    = K_SEQ;
    is_call = 1'b0;
    sense   = 1'b1;
    if (top_nib == 4'hA || top_nib == 4'hB) begin
      kind    = K_PCREL;
      is_call = (top_nib == 4'hB);
    end else if (hi_byte == 8'h89 || hi_byte == 8'h8B) begin
      kind  = K_IMMCOND;
      sense = (hi_byte == 8'h89);
    end else if (hi_byte == 8'h8D || hi_byte == 8'h8F) begin
      kind  = K_DLYCOND;
      sense = (hi_byte == 8'h8D);
    end else if (top_nib == 4'h0 && (lo_byte == 8'h23 || lo_byte == 8'h03)) begin
      kind    = K_REGREL;
      is_call = (lo_byte == 8'h03);
    end else if (top_nib == 4'h4 && (lo_byte == 8'h2B || lo_byte == 8'h0B)) begin
      kind    = K_REGABS;
      is_call = (lo_byte == 8'h0B);
    end else if (opcode == 16'h000B || opcode == 16'h002B) begin
      kind = K_REGABS;
    end else if (hi_byte == 8'hC3) begin
      kind = K_TRAP;
    end
  end
endmodule

// File: rtl/dbc_target.sv
module dbc_target
  import dbc_pkg::*;
(
  input  flow_kind_e         kind,
  input  logic [LDISP_W-1:0] disp,
  input  addr_t              pc,
  input  addr_t              opnd,
  output addr_t              target
);
  always_comb begin
    unique case (kind)
      K_PCREL:             target = ahead(pc) + long_off(disp);
      K_IMMCOND, K_DLYCOND: target = ahead(pc) + short_off(disp[SDISP_W-1:0]);
      K_REGREL:            target = ahead(pc) + opnd;
      K_REGABS:            target = opnd;
      default:             target = next_seq(pc);
    endcase
  end
endmodule

// File: rtl/dbc_slot.sv
module dbc_slot
  import dbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm,
  input  logic  arm_take,
  input  addr_t arm_tgt,
  output logic  in_slot,
  output logic  take_q,
  output addr_t tgt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_slot <= 1'b0;
      take_q  <= 1'b0;
      tgt_q   <= '0;
    end else if (arm) begin
      in_slot <= 1'b1;
      take_q  <= arm_take;
      tgt_q   <= arm_tgt;
    end else begin
      in_slot <= 1'b0;
      take_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/dbc_branch_seq.sv
module dbc_branch_seq
  import dbc_pkg::*;
#(
  parameter addr_t RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] opcode,
  input  logic              t_flag,
  input  logic [ADDR_W-1:0] opnd,
  output logic [ADDR_W-1:0] pc,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              slot_illegal,
  output logic              in_slot
);
  flow_kind_e kind;
  logic       is_call, sense;
  addr_t      target, tgt_q, pc_q, pc_d;
  logic       take_q;

  // Named events used by the checker.
  logic is_flow, cond_hit, imm_taken, arm, arm_take, redirect;

  dbc_decode u_dec (
    .opcode (opcode),
    .kind   (kind),
    .is_call(is_call),
    .sense  (sense)
  );

  dbc_target u_tgt (
    .kind  (kind),
    .disp  (opcode[LDISP_W-1:0]),
    .pc    (pc_q),
    .opnd  (opnd),
    .target(target)
  );

  assign is_flow   = (kind != K_SEQ);
  assign cond_hit  = (t_flag == sense);
  assign imm_taken = !in_slot && (kind == K_IMMCOND) && cond_hit;
  assign arm       = !in_slot && (kind inside {K_DLYCOND, K_PCREL, K_REGREL, K_REGABS});
  assign arm_take  = (kind != K_DLYCOND) || cond_hit;
  assign redirect  = in_slot && take_q;

  dbc_slot u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .arm_take(arm_take),
    .arm_tgt (target),
    .in_slot (in_slot),
    .take_q  (take_q),
    .tgt_q   (tgt_q)
  );

  always_comb begin
    if (redirect)       pc_d = tgt_q;
    else if (imm_taken) pc_d = target;
    else                pc_d = next_seq(pc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc           = pc_q;
  assign link_we      = !in_slot && is_call;
  assign link_val     = ahead(pc_q);
  assign slot_illegal = in_slot && is_flow;
endmodule

// File: rtl/dbc_chk.sv
module dbc_chk
  import dbc_pkg::*;
#(
  parameter addr_t RESET_PC = 32'hA000_0000
) (
  input logic       clk,
  input logic       rst_n,
  input addr_t      pc,
  input logic       in_slot,
  input logic       take_q,
  input addr_t      tgt_q,
  input logic       is_flow,
  input flow_kind_e kind,
  input logic       link_we,
  input addr_t      link_val,
  input logic       slot_illegal
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pc == RESET_PC && !in_slot));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot && !is_flow) |=> (pc == $past(pc) + addr_t'(SEQ_STEP)));

  a_r3_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot && kind == K_IMMCOND) |=> !in_slot);

  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && take_q) |=> (pc == $past(tgt_q)));

  a_r5_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_val == pc + addr_t'(PIPE_OFS) && !in_slot));

  a_r9_slot_trap: assert property (@(posedge clk) disable iff (!rst_n)
    slot_illegal |-> (in_slot && !link_we));

  a_r10_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |=> !in_slot);
endmodule

bind dbc_branch_seq dbc_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc          (pc_q),
  .in_slot     (in_slot),
  .take_q      (take_q),
  .tgt_q       (tgt_q),
  .is_flow     (is_flow),
  .kind        (kind),
  .link_we     (link_we),
  .link_val    (link_val),
  .slot_illegal(slot_illegal)
);

// File: tb/sim_dbc_branch_seq.sv
module sim_dbc_branch_seq;
  localparam logic [31:0] RST_PC = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opcode = 16'h0009;
  logic        t_flag = 1'b0;
  logic [31:0] opnd = '0;
  logic [31:0] pc, link_val;
  logic        link_we, slot_illegal, in_slot;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model state.
  logic [31:0] m_pc = RST_PC;
  logic        m_slot = 0;
  logic        m_take = 0;
  logic [31:0] m_tgt = '0;
  string       m_tag = "R1";
  string       m_dtag = "R4";

  always #2 clk = ~clk;

  dbc_branch_seq u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .t_flag(t_flag), .opnd(opnd),
    .pc(pc), .link_we(link_we), .link_val(link_val),
    .slot_illegal(slot_illegal), .in_slot(in_slot)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 seq, 1 imm cond, 2 delayed cond, 3 pc-rel, 4 reg-rel, 5 reg-abs, 6 trap
  function automatic int classify(input logic [15:0] op, output bit call,
                                  output bit on_true);
    call = 0; on_true = 0;
    casez (op)
      16'hA???: return 3;
      16'hB???: begin call = 1; return 3; end
      16'h89??: begin on_true = 1; return 1; end
      16'h8B??: return 1;
      16'h8D??: begin on_true = 1; return 2; end
      16'h8F??: return 2;
      16'h0?23: return 4;
      16'h0?03: begin call = 1; return 4; end
      16'h4?2B: return 5;
      16'h4?0B: begin call = 1; return 5; end
      16'h000B, 16'h002B: return 5;
      16'hC3??: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_target(input int cls, input logic [15:0] op,
                                             input logic [31:0] p, input logic [31:0] r);
    case (cls)
      3: return p + 32'd4 + {{19{op[11]}}, op[11:0], 1'b0};
      1, 2: return p + 32'd4 + {{23{op[7]}}, op[7:0], 1'b0};
      4: return r + p + 32'd4;
      default: return r;
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [15:0] op, input logic t, input logic [31:0] r);
    bit call, on_true;
    int cls;
    logic [31:0] npc;
    string ntag;
    opcode = op; t_flag = t; opnd = r;
    #1;
    cls = classify(op, call, on_true);
    chk(pc == m_pc, m_tag, pc, m_pc);
    chk(in_slot == m_slot, "R10", {31'd0, in_slot}, {31'd0, m_slot});
    chk(link_we == (call && !m_slot), "R5", {31'd0, link_we}, {31'd0, call && !m_slot});
    if (call && !m_slot) chk(link_val == m_pc + 32'd4, "R5", link_val, m_pc + 32'd4);
    chk(slot_illegal == (m_slot && cls != 0), "R9", {31'd0, slot_illegal},
        {31'd0, m_slot && cls != 0});
    if (m_slot) begin
      npc  = m_take ? m_tgt : m_pc + 32'd2;
      ntag = (cls != 0) ? "R9" : m_dtag;
      m_slot = 0; m_take = 0;
    end else begin
      npc = m_pc + 32'd2;
      ntag = "R2";
      case (cls)
        1: begin
          ntag = "R3";
          if (t == on_true) npc = exp_target(cls, op, m_pc, r);
        end
        2, 3, 4, 5: begin
          m_slot = 1;
          m_take = (cls != 2) || (t == on_true);
          m_tgt  = exp_target(cls, op, m_pc, r);
          m_dtag = (cls == 2) ? "R6" : (cls == 3) ? "R4" : (cls == 4) ? "R7" : "R8";
          ntag   = m_dtag;
        end
        default: ;
      endcase
    end
    m_pc = npc; m_tag = ntag;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    opcode = 16'h0009;
    @(negedge clk);
    #1;
    chk(pc == RST_PC, "R1", pc, RST_PC);
    chk(in_slot == 1'b0, "R1", {31'd0, in_slot}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    m_pc = RST_PC; m_slot = 0; m_take = 0; m_tag = "R1";
  endtask

  function automatic logic [15:0] rand_op();
    logic [15:0] r16 = 16'($urandom);
    case ($urandom % 12)
      0, 1, 2: return {4'h6, r16[11:0]};
      3: return {8'h89, r16[7:0]};
      4: return {8'h8B, r16[7:0]};
      5: return {8'h8D, r16[7:0]};
      6: return {8'h8F, r16[7:0]};
      7: return {r16[15] ? 4'hB : 4'hA, r16[11:0]};
      8: return {4'h0, r16[3:0], r16[4] ? 8'h23 : 8'h03};
      9: return {4'h4, r16[3:0], r16[4] ? 8'h2B : 8'h0B};
      10: return r16[0] ? 16'h000B : (r16[1] ? 16'h002B : {8'hC3, r16[7:0]});
      default: return r16;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R2: plain instructions
    step(16'h0009, 0, 0);
    step(16'h6003, 1, 0);
    // R2: trap outside a slot is sequential
    step(16'hC320, 0, 0);
    // R3: taken with negative displacement, then not taken
    step(16'h89FE, 1, 0);
    step(16'h8B10, 1, 0);
    step(16'h8B7F, 0, 0);
    // R4: extreme forward and backward displacements
    step(16'hA7FF, 0, 0); step(16'h0009, 0, 0);
    step(16'hB800, 0, 0); step(16'h0009, 0, 0);
    // R6: T sampled at the branch, flipped during the slot
    step(16'h8D04, 1, 0); step(16'h0009, 0, 0);
    step(16'h8F04, 1, 0); step(16'h0009, 0, 0);
    // R7: register-relative wrap-around
    step(16'h0523, 0, 32'hFFFF_FFF0); step(16'h0009, 0, 0);
    // R8: absolute call and return
    step(16'h420B, 0, 32'h0000_1000); step(16'h0009, 0, 0);
    step(16'h000B, 0, 32'h0000_2000); step(16'h0009, 0, 0);
    // R9: branch, call, trap in a slot
    step(16'hA010, 0, 0); step(16'hB020, 0, 0);
    step(16'h402B, 0, 32'h3000); step(16'h8901, 1, 0);
    step(16'h8D02, 1, 0); step(16'hC301, 0, 0);
    // R1: reset while a redirect is pending
    step(16'hA100, 0, 0);
    do_reset();
    for (int i = 0; i < 4000; i++) step(rand_op(), 1'($urandom), $urandom);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule